// File: doc/BRIEF.md
# Transmit Buffer Read Sequencer

This block paces the buffer reads of a digital audio serial transmitter. It runs on an internal clock at 128 times the sample rate. It counts the cycles of each frame and the frames of a 192-frame block. At the parity-bit slot of selected sub-frames, it drives an address and a read strobe into a small shared byte RAM. The byte that comes back is latched into one of three holding registers: left channel status, right channel status or user data.

The channel-status bytes come from a fixed map. Bytes 0 to 3 of each channel have their own four addresses. Every later group of four bytes reuses one shared window of four addresses. User bytes rotate through a separate window of four addresses.

Three flags tell a host which part of the buffer is being read. A flag edge can pull a maskable, active-low interrupt. The host uses the interrupt and the flags to keep its writes away from the byte being fetched. The interrupt stays asserted until the host acknowledges it.

Top module: `tx_buf_rd_seq`

## Requirements
- R1: While `rst_ni` is low, the outputs hold these values: `ram_addr_o` = 0x08, `ram_rd_o` = 0, `flag_o` = 3'b100, `irq_no` = 1, and all three fetched bytes = 0.
- R2: Timing after reset release:
  - A frame is 128 cycles. The left sub-frame is cycles 0–63 and the right sub-frame is cycles 64–127.
  - The parity slot is the last two cycles of each sub-frame.
  - `ram_rd_o` is high for exactly those two cycles, and only when a read is scheduled.
  - Frames with frame%8 = 0 read left status in the left parity slot and right status in the right parity slot.
  - Frames with frame%4 = 2 read user data in the left parity slot.
  - No other read occurs.
- R3: A left status read of byte b = frame/8 uses address 0x08+b when b < 4, and 0x0C+(b%4) otherwise. After 192 frames the sequence restarts at 0x08.
- R4: A right status read of byte b uses address 0x10+b when b < 4, and 0x14+(b%4) otherwise. After 192 frames the sequence restarts at 0x10.
- R5: A user read with index u = frame/4 uses address 0x04+(u%4).
- R6: During a strobe, `ram_addr_o` does not change. `ram_rdata_i` is sampled at the edge that ends the second strobe cycle and loaded into `cs_left_o`, `cs_right_o` or `user_o`, depending on the read type. Each of these outputs holds its value at all other times.
- R7: `flag_o` changes only in the first cycle of a strobe:
  - `flag_o[0]` is bit 1 of the latest left status byte index.
  - `flag_o[2]` is high when that index is below 4.
  - `flag_o[1]` is bit 1 of (latest user index % 4).
- R8: `irq_no` falls in the same cycle as a change of flag bit k, if `irq_mask_i[k]` was 1 in the previous cycle. Flag changes on masked-off bits leave `irq_no` unchanged.
- R9: Once low, `irq_no` stays low until `irq_ack_i` is high at a clock edge. It is high after that edge, unless a new interrupt is raised at the same edge.
- R10: Asserting `rst_ni` in the middle of a run returns every output to the R1 values at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, 128 × sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_mask_i | input | 3 | Interrupt enable per flag bit |
| irq_ack_i | input | 1 | Host acknowledge, clears the interrupt |
| ram_rdata_i | input | DW | Byte returned by the buffer RAM |
| ram_addr_o | output | AW | Buffer RAM read address |
| ram_rd_o | output | 1 | Read strobe, high for the parity slot |
| flag_o | output | 3 | Section flags: [0] status half, [1] user half, [2] first group |
| irq_no | output | 1 | Interrupt, active low |
| cs_left_o | output | DW | Latest left channel-status byte |
| cs_right_o | output | DW | Latest right channel-status byte |
| user_o | output | DW | Latest user-data byte |

## Verification
The bench builds the block with its default parameters: 192 frames per block, 128 cycles per frame, 8 frames per status byte, 4 frames per user byte, and groups of four addresses. These values bring the whole address map within reach in about 25k cycles per block. The run covers four full blocks, so the wrap from byte 23 back to the first group is seen three times. Each block uses a different interrupt mask (none, bits 0 and 2, bit 1 only, all), so masked and unmasked edges of every flag occur. Acknowledges are issued mid-frame, and a final reset lands in the middle of a frame.

// File: rtl/tbrs_pkg.sv
package tbrs_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CS_L = 2'd1,
    RD_CS_R = 2'd2,
    RD_USER = 2'd3
  } rd_kind_e;

  localparam int unsigned NFLAGS = 3;
  localparam int unsigned NCAPS  = 3;
endpackage

// File: rtl/tbrs_timer.sv
module tbrs_timer #(
  parameter int unsigned CYC_PER_FRAME    = 128,
  parameter int unsigned FRAMES_PER_BLOCK = 192,
  localparam int unsigned CW = $clog2(CYC_PER_FRAME),
  localparam int unsigned FW = $clog2(FRAMES_PER_BLOCK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cyc_o,
  output logic [FW-1:0] frame_o
);
  logic [CW-1:0] cyc_q;
  logic [FW-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      frame_q <= '0;
    end else if (cyc_q == CW'(CYC_PER_FRAME - 1)) begin
      cyc_q   <= '0;
      frame_q <= (frame_q == FW'(FRAMES_PER_BLOCK - 1)) ? '0 : frame_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign cyc_o   = cyc_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/tbrs_addr_gen.sv
module tbrs_addr_gen
  import tbrs_pkg::*;
#(
  parameter int unsigned CYC_PER_FRAME        = 128,
  parameter int unsigned FRAMES_PER_BLOCK     = 192,
  parameter int unsigned FRAMES_PER_CS_BYTE   = 8,
  parameter int unsigned FRAMES_PER_USER_BYTE = 4,
  parameter int unsigned CS_GROUP             = 4,
  parameter int unsigned USER_SLOTS           = 4,
  parameter int unsigned AW                   = 5,
  parameter int unsigned CS_L_HEAD            = 8,
  parameter int unsigned CS_L_TAIL            = 12,
  parameter int unsigned CS_R_HEAD            = 16,
  parameter int unsigned CS_R_TAIL            = 20,
  parameter int unsigned USER_BASE            = 4,
  localparam int unsigned CW   = $clog2(CYC_PER_FRAME),
  localparam int unsigned FW   = $clog2(FRAMES_PER_BLOCK),
  localparam int unsigned HALF = CYC_PER_FRAME / 2
) (
  input  logic [CW-1:0] cyc_i,
  input  logic [FW-1:0] frame_i,
  output rd_kind_e      kind_o,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          arm_o,
  output logic          last_o,
  output logic [FW-1:0] cs_byte_o,
  output logic [FW-1:0] user_idx_o
);
  logic          sub;
  logic [CW-1:0] pos;
  logic [FW-1:0] cs_byte, cs_phase, user_idx, user_phase;
  logic          cs_slot, user_slot;

  assign sub = cyc_i >= CW'(HALF);
  assign pos = sub ? cyc_i - CW'(HALF) : cyc_i;

  assign cs_byte    = frame_i / FW'(FRAMES_PER_CS_BYTE);
  assign cs_phase   = frame_i % FW'(FRAMES_PER_CS_BYTE);
  assign user_idx   = frame_i / FW'(FRAMES_PER_USER_BYTE);
  assign user_phase = frame_i % FW'(FRAMES_PER_USER_BYTE);

  assign cs_slot   = cs_phase == '0;
  assign user_slot = user_phase == FW'(FRAMES_PER_USER_BYTE / 2);

  always_comb begin
    kind_o = RD_NONE;
    if (cs_slot)                kind_o = sub ? RD_CS_R : RD_CS_L;
    else if (user_slot && !sub) kind_o = RD_USER;
  end

  // first group has its own window, later groups share one
  always_comb begin
    unique case (kind_o)
      RD_CS_L: addr_o = (cs_byte < FW'(CS_GROUP))
                        ? AW'(FW'(CS_L_HEAD) + cs_byte)
                        : AW'(FW'(CS_L_TAIL) + (cs_byte % FW'(CS_GROUP)));
      RD_CS_R: addr_o = (cs_byte < FW'(CS_GROUP))
                        ? AW'(FW'(CS_R_HEAD) + cs_byte)
                        : AW'(FW'(CS_R_TAIL) + (cs_byte % FW'(CS_GROUP)));
      default: addr_o = AW'(FW'(USER_BASE) + (user_idx % FW'(USER_SLOTS)));
    endcase
  end

  assign rd_o       = (pos >= CW'(HALF - 2)) && (kind_o != RD_NONE);
  assign arm_o      = pos == CW'(HALF - 3);
  assign last_o     = pos == CW'(HALF - 1);
  assign cs_byte_o  = cs_byte;
  assign user_idx_o = user_idx;
endmodule

// File: rtl/tbrs_flags.sv
module tbrs_flags
  import tbrs_pkg::*;
#(
  parameter int unsigned FW         = 8,
  parameter int unsigned CS_GROUP   = 4,
  parameter int unsigned USER_SLOTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  rd_kind_e          kind_i,
  input  logic [FW-1:0]     cs_byte_i,
  input  logic [FW-1:0]     user_idx_i,
  input  logic [NFLAGS-1:0] mask_i,
  input  logic              ack_i,
  output logic [NFLAGS-1:0] flag_o,
  output logic              irq_no
);
  logic [NFLAGS-1:0] fl_q, fl_d;
  logic              irq_q, irq_set;

  always_comb begin
    fl_d = fl_q;
    if (arm_i && kind_i == RD_CS_L) begin
      fl_d[0] = (cs_byte_i % FW'(CS_GROUP)) >= FW'(CS_GROUP / 2);
      fl_d[2] = cs_byte_i < FW'(CS_GROUP);
    end
    if (arm_i && kind_i == RD_USER) begin
      fl_d[1] = (user_idx_i % FW'(USER_SLOTS)) >= FW'(USER_SLOTS / 2);
    end
  end

  assign irq_set = |((fl_d ^ fl_q) & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q  <= 3'b100;
      irq_q <= 1'b0;
    end else begin
      fl_q <= fl_d;
      if (irq_set)    irq_q <= 1'b1;  // set beats ack
      else if (ack_i) irq_q <= 1'b0;
    end
  end

  assign flag_o = fl_q;
  assign irq_no = ~irq_q;
endmodule

// File: rtl/tx_buf_rd_seq.sv
module tx_buf_rd_seq
  import tbrs_pkg::*;
#(
  parameter int unsigned CYC_PER_FRAME        = 128,
  parameter int unsigned FRAMES_PER_BLOCK     = 192,
  parameter int unsigned FRAMES_PER_CS_BYTE   = 8,
  parameter int unsigned FRAMES_PER_USER_BYTE = 4,
  parameter int unsigned CS_GROUP             = 4,
  parameter int unsigned USER_SLOTS           = 4,
  parameter int unsigned AW                   = 5,
  parameter int unsigned DW                   = 8,
  parameter int unsigned CS_L_HEAD            = 8,
  parameter int unsigned CS_L_TAIL            = 12,
  parameter int unsigned CS_R_HEAD            = 16,
  parameter int unsigned CS_R_TAIL            = 20,
  parameter int unsigned USER_BASE            = 4,
  localparam int unsigned CW = $clog2(CYC_PER_FRAME),
  localparam int unsigned FW = $clog2(FRAMES_PER_BLOCK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NFLAGS-1:0] irq_mask_i,
  input  logic              irq_ack_i,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic [AW-1:0]     ram_addr_o,
  output logic              ram_rd_o,
  output logic [NFLAGS-1:0] flag_o,
  output logic              irq_no,
  output logic [DW-1:0]     cs_left_o,
  output logic [DW-1:0]     cs_right_o,
  output logic [DW-1:0]     user_o
);
  logic [CW-1:0] cyc;
  logic [FW-1:0] frame, cs_byte, user_idx;
  rd_kind_e      kind;
  logic          arm, last;
  logic [DW-1:0] cap_q [NCAPS];

  tbrs_timer #(
    .CYC_PER_FRAME   (CYC_PER_FRAME),
    .FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)
  ) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cyc_o  (cyc),
    .frame_o(frame)
  );

  tbrs_addr_gen #(
    .CYC_PER_FRAME       (CYC_PER_FRAME),
    .FRAMES_PER_BLOCK    (FRAMES_PER_BLOCK),
    .FRAMES_PER_CS_BYTE  (FRAMES_PER_CS_BYTE),
    .FRAMES_PER_USER_BYTE(FRAMES_PER_USER_BYTE),
    .CS_GROUP            (CS_GROUP),
    .USER_SLOTS          (USER_SLOTS),
    .AW                  (AW),
    .CS_L_HEAD           (CS_L_HEAD),
    .CS_L_TAIL           (CS_L_TAIL),
    .CS_R_HEAD           (CS_R_HEAD),
    .CS_R_TAIL           (CS_R_TAIL),
    .USER_BASE           (USER_BASE)
  ) i_addr_gen (
    .cyc_i     (cyc),
    .frame_i   (frame),
    .kind_o    (kind),
    .addr_o    (ram_addr_o),
    .rd_o      (ram_rd_o),
    .arm_o     (arm),
    .last_o    (last),
    .cs_byte_o (cs_byte),
    .user_idx_o(user_idx)
  );

  tbrs_flags #(
    .FW        (FW),
    .CS_GROUP  (CS_GROUP),
    .USER_SLOTS(USER_SLOTS)
  ) i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .kind_i    (kind),
    .cs_byte_i (cs_byte),
    .user_idx_i(user_idx),
    .mask_i    (irq_mask_i),
    .ack_i     (irq_ack_i),
    .flag_o    (flag_o),
    .irq_no    (irq_no)
  );

  // one holding register per read type, slot k serves kind k+1
  for (genvar k = 0; k < NCAPS; k++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cap_q[k] <= '0;
      else if (ram_rd_o && last && kind == rd_kind_e'(2'(k + 1))) cap_q[k] <= ram_rdata_i;
    end
  end

  assign cs_left_o  = cap_q[0];
  assign cs_right_o = cap_q[1];
  assign user_o     = cap_q[2];
endmodule

// File: rtl/tbrs_chk.sv
module tbrs_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    irq_mask_i,
  input logic          irq_ack_i,
  input logic [AW-1:0] ram_addr_o,
  input logic          ram_rd_o,
  input logic [2:0]    flag_o,
  input logic          irq_no
);
  // R2
  rd_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_rd_o) |=> ram_rd_o);

  // R2
  rd_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd_o && $past(ram_rd_o) |=> !ram_rd_o);

  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd_o && $past(ram_rd_o) |-> $stable(ram_addr_o));

  // R3 R4 R5
  addr_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd_o |-> (ram_addr_o >= AW'(4)) && (ram_addr_o <= AW'(23)));

  // R7
  flag_at_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o != $past(flag_o)) |-> $rose(ram_rd_o));

  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> |((flag_o ^ $past(flag_o)) & $past(irq_mask_i)));

  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no && !irq_ack_i |=> !irq_no);

  // R9
  irq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_no) |-> $past(irq_ack_i));
endmodule

bind tx_buf_rd_seq tbrs_chk #(.AW(AW)) i_tbrs_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_mask_i(irq_mask_i),
  .irq_ack_i (irq_ack_i),
  .ram_addr_o(ram_addr_o),
  .ram_rd_o  (ram_rd_o),
  .flag_o    (flag_o),
  .irq_no    (irq_no)
);

// File: tb/test_tx_buf_rd_seq.sv
`timescale 1ns/1ps
module test_tx_buf_rd_seq;
  localparam int BLK = 192 * 128;

  typedef struct packed {
    int         cyc;
    logic [4:0] addr;
    logic [1:0] kind;
    int         idx;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [2:0] mask;
  logic       ack;
  logic [7:0] rdata;
  logic [4:0] ram_addr;
  logic       ram_rd;
  logic [2:0] flag;
  logic       irq_n;
  logic [7:0] cs_l, cs_r, usr;

  logic [7:0] mem [32];
  exp_t       exp_q [$];
  int         t, n_chk, n_fail;
  bit         done;

  always #5 clk = ~clk;

  assign rdata = mem[ram_addr];

  tx_buf_rd_seq i_tx_buf_rd_seq (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .irq_mask_i (mask),
    .irq_ack_i  (ack),
    .ram_rdata_i(rdata),
    .ram_addr_o (ram_addr),
    .ram_rd_o   (ram_rd),
    .flag_o     (flag),
    .irq_no     (irq_n),
    .cs_left_o  (cs_l),
    .cs_right_o (cs_r),
    .user_o     (usr)
  );

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) t <= 0;
    else         t <= t + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, t);
    end
  endtask

  task automatic fill_mem(input int blk);
    for (int i = 0; i < 32; i++) mem[i] = 8'(i * 37 + blk * 11) ^ 8'h5A;
  endtask

  // driver: expected reads of one block
  task automatic push_block(input int blk);
    for (int f = 0; f < 192; f++) begin
      int base = blk * BLK + f * 128;
      if (f % 8 == 0) begin
        int b = f / 8;
        exp_q.push_back('{base + 62, 5'((b < 4) ? 8 + b : 12 + b % 4), 2'd1, b});
        exp_q.push_back('{base + 126, 5'((b < 4) ? 16 + b : 20 + b % 4), 2'd2, b});
      end else if (f % 4 == 2) begin
        int u = f / 4;
        exp_q.push_back('{base + 62, 5'(4 + u % 4), 2'd3, u});
      end
    end
  endtask

  task automatic reset_state_chk(input string req);
    chk(ram_addr == 5'h08, req, ram_addr, 8);
    chk(ram_rd == 1'b0, req, ram_rd, 0);
    chk(flag == 3'b100, req, flag, 4);
    chk(irq_n == 1'b1, req, irq_n, 1);
    chk({cs_l, cs_r, usr} == 24'h0, req, {cs_l, cs_r, usr}, 0);
  endtask

  // monitor
  initial begin
    exp_t       cur;
    bit         prev_rd, irq_exp;
    logic [2:0] fl_exp, nf;
    logic [7:0] exp_data;
    int         rise_t;
    prev_rd = 0; irq_exp = 0; fl_exp = 3'b100; rise_t = 0; exp_data = '0; cur = '0;
    forever begin
      @(negedge clk);
      if (!rst_ni || done) begin
        prev_rd = 0;
        continue;
      end
      if (ack) begin
        ack = 1'b0;
        irq_exp = 0;
        chk(irq_n == 1'b1, "R9 ack clears", irq_n, 1);
      end
      if (ram_rd && !prev_rd) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected read", ram_addr, 0);
        else begin
          cur = exp_q.pop_front();
          chk(t == cur.cyc, "R2 read slot", t, cur.cyc);
          case (cur.kind)
            2'd1:    chk(ram_addr == cur.addr, "R3 left addr", ram_addr, cur.addr);
            2'd2:    chk(ram_addr == cur.addr, "R4 right addr", ram_addr, cur.addr);
            default: chk(ram_addr == cur.addr, "R5 user addr", ram_addr, cur.addr);
          endcase
          nf = fl_exp;
          if (cur.kind == 2'd1) begin
            nf[0] = (cur.idx % 4) >= 2;
            nf[2] = cur.idx < 4;
          end
          if (cur.kind == 2'd3) nf[1] = (cur.idx % 4) >= 2;
          if (|((nf ^ fl_exp) & mask)) irq_exp = 1;
          fl_exp = nf;
          chk(flag == fl_exp, "R7 flags", flag, fl_exp);
          chk(irq_n == !irq_exp, "R8 irq", irq_n, !irq_exp);
          exp_data = mem[cur.addr];
          rise_t = t;
        end
      end
      if (!ram_rd && prev_rd) begin
        chk(t == rise_t + 2, "R2 strobe length", t - rise_t, 2);
        case (cur.kind)
          2'd1:    chk(cs_l == exp_data, "R6 left capture", cs_l, exp_data);
          2'd2:    chk(cs_r == exp_data, "R6 right capture", cs_r, exp_data);
          default: chk(usr == exp_data, "R6 user capture", usr, exp_data);
        endcase
        chk(irq_n == !irq_exp, "R9 hold", irq_n, !irq_exp);
      end
      if (irq_exp && (t % 128 == 100) && !ack) ack = 1'b1;
      prev_rd = ram_rd;
    end
  end

  // stimulus
  initial begin
    logic [2:0] masks [4];
    masks[0] = 3'b000; masks[1] = 3'b101; masks[2] = 3'b010; masks[3] = 3'b111;
    n_chk = 0; n_fail = 0; done = 0;
    rst_ni = 1'b0; ack = 1'b0; mask = masks[0];
    fill_mem(0);
    for (int b = 0; b < 4; b++) push_block(b);
    repeat (3) @(negedge clk);
    reset_state_chk("R1 reset state");
    rst_ni = 1'b1;
    for (int b = 1; b < 4; b++) begin
      while (t != b * BLK) @(negedge clk);
      fill_mem(b);
      mask = masks[b];
    end
    while (t != 4 * BLK + 20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads seen", exp_q.size(), 0);
    chk(cs_l != 8'h00 || cs_r != 8'h00, "R10 state before reset", {cs_l, cs_r}, 1);
    rst_ni = 1'b0;
    #1;
    reset_state_chk("R10 mid-run reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected end before limit", t);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule